// File: doc/BRIEF.md
# Serial Field Memory Write Port

This block is the write half of a field-delay FIFO memory. Words arrive one per write clock together with a write-enable and an input-enable. A write address pointer walks through a two-dimensional array, row after row. Incoming words are staged in a one-row buffer, and the buffer is committed to an external array through a wide row-write port. A per-column mask travels with each row write, so that columns whose words were suppressed keep their old contents in the array.

Write-enable low freezes the pointer. Input-enable low lets the pointer advance while the addressed location is left unchanged, which allows a window to be written into a frame that is otherwise kept. A pointer reset request is sampled on the write clock. A reset that comes too soon after the previous one is rejected and reported. A reset also flushes a partly filled row to the array. A completed pass that had too few active cycles is reported on a short-pass flag.

Top module: `field_wr_port`

## Requirements
- R1: A clock edge on which `rst_req` is high is an accepted reset when `rst_req` was low on at least the two preceding edges, or when no edge has sampled `rst_req` high since `rst_n` was released. On an accepted reset `wr_ptr` becomes 0.
- R2: On an accepted reset, `we`, `ie` and `din` have no effect: nothing is stored and the pointer does not advance.
- R3: An edge with `rst_req` high that is not an accepted reset is rejected. `rst_err` is high for exactly the cycle after that edge, and the edge is treated as an ordinary write or idle cycle.
- R4: On a non-reset edge with `we` low, `wr_ptr` keeps its value for any number of cycles and no word is stored.
- R5: On a non-reset edge with `we` high, `wr_ptr` increments by one. It wraps from 2^(ROW_W+COL_W)-1 to 0. The low COL_W bits of `wr_ptr` are the column and the upper ROW_W bits are the row.
- R6: On a non-reset edge with `we` high and `ie` low, the pointer advances but the addressed array location keeps its previous contents, because its mask bit stays 0.
- R7: A write edge at column 2^COL_W-1 commits the row. In the cycle after that edge, `arr_we` is 1 and `arr_row` holds the row. `arr_mask` bit c is set for each column c stored with `ie` high since the last commit, and that word sits at `arr_data[c*DATA_W +: DATA_W]`. When no bit would be set, `arr_we` stays 0.
- R8: An accepted reset commits the pending columns of the partly filled row in the same way as R7, using the row of `wr_ptr` before the reset. Pending words are not committed by anything else.
- R9: At each accepted reset, `short_pass` takes the value 1 when an earlier accepted reset opened a pass and fewer than MIN_ACTIVE write cycles (non-reset edges with `we` high) have occurred since then. Otherwise it takes 0. It keeps that value until the next accepted reset and is 0 after `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_req | input | 1 | Pointer reset request, sampled on the clock |
| we | input | 1 | Write enable; low freezes the pointer |
| ie | input | 1 | Input enable; low suppresses the store only |
| din | input | DATA_W | Input word |
| wr_ptr | output | ROW_W+COL_W | Current write address |
| arr_we | output | 1 | Row commit strobe to the array |
| arr_row | output | ROW_W | Row being committed |
| arr_data | output | DATA_W*2^COL_W | Row data, column c at bits c*DATA_W |
| arr_mask | output | 2^COL_W | Per-column write mask |
| rst_err | output | 1 | Pulse for a rejected, too-early reset request |
| short_pass | output | 1 | Last completed pass was shorter than MIN_ACTIVE |

## Verification
The case that is hardest to reach from the ports is masking that persists across passes. A location skipped with `ie` low must still hold what an earlier pass wrote there. That old value is only visible once a later flush or a row wrap has pushed the new row's mask to the array. The stimulus therefore fills the whole small array in one long pass that also wraps the pointer. A second pass then writes every location with a column-dependent `ie` pattern and ends with a flushing reset. Every address is then compared against a bench-side copy of the array. The back-to-back and too-early reset requests are driven from a vector table so that the rejection window falls between accepted resets.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  // Classification of one write clock edge, shared by pointer and line stage
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_WRITE = 2'd1,
    CYC_RESET = 2'd2
  } cyc_kind_t;

  // Number of low samples required between two accepted resets
  localparam int unsigned RST_GAP = 2;
endpackage

// File: rtl/fwp_ptr_ctl.sv
module fwp_ptr_ctl
  import fwp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned MIN_ACTIVE = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_req,
  input  logic              we,
  output cyc_kind_t         kind,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic              rst_err,
  output logic              short_pass
);
  localparam int unsigned CNT_W = $clog2(MIN_ACTIVE + 1);
  localparam int unsigned GAP_W = $clog2(RST_GAP + 1);

  logic [GAP_W-1:0] low_run;
  logic [CNT_W-1:0] act_cnt;
  logic             pass_open;

  // named internal events
  logic rst_accept;
  logic rst_reject;
  logic write_evt;

  function automatic logic [GAP_W-1:0] low_run_next(input logic req, input logic [GAP_W-1:0] cur);
    if (req) return '0;
    if (cur >= GAP_W'(RST_GAP)) return GAP_W'(RST_GAP);
    return cur + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_sat_inc(input logic [CNT_W-1:0] cur);
    if (cur >= CNT_W'(MIN_ACTIVE)) return CNT_W'(MIN_ACTIVE);
    return cur + 1'b1;
  endfunction

  assign rst_accept = rst_req && (low_run >= GAP_W'(RST_GAP));
  assign rst_reject = rst_req && !rst_accept;
  assign write_evt  = we && !rst_accept;

  always_comb begin
    if (rst_accept)     kind = CYC_RESET;
    else if (write_evt) kind = CYC_WRITE;
    else                kind = CYC_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run    <= GAP_W'(RST_GAP);
      act_cnt    <= '0;
      pass_open  <= 1'b0;
      wr_ptr     <= '0;
      rst_err    <= 1'b0;
      short_pass <= 1'b0;
    end else begin
      low_run <= low_run_next(rst_req, low_run);
      rst_err <= rst_reject;
      if (rst_accept) begin
        short_pass <= pass_open && (act_cnt < CNT_W'(MIN_ACTIVE));
        pass_open  <= 1'b1;
        act_cnt    <= '0;
        wr_ptr     <= '0;
      end else if (write_evt) begin
        act_cnt <= cnt_sat_inc(act_cnt);
        wr_ptr  <= wr_ptr + 1'b1;
      end
    end
  end

  // R1
  rst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_accept |=> (wr_ptr == '0));

  // R3
  reset_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_accept |=> !rst_accept);

  // R4
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_IDLE) |=> $stable(wr_ptr));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_WRITE) |=> (wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1)));
endmodule

// File: rtl/fwp_line_stage.sv
module fwp_line_stage
  import fwp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned COL_W  = 9,
  parameter int unsigned ROW_W  = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  cyc_kind_t                     kind,
  input  logic                          ie,
  input  logic [DATA_W-1:0]             din,
  input  logic [ROW_W+COL_W-1:0]        wr_ptr,
  output logic                          arr_we,
  output logic [ROW_W-1:0]              arr_row,
  output logic [DATA_W*(1<<COL_W)-1:0]  arr_data,
  output logic [(1<<COL_W)-1:0]         arr_mask
);
  localparam int unsigned COLS   = 1 << COL_W;
  localparam int unsigned ADDR_W = ROW_W + COL_W;

  logic [DATA_W-1:0]      buf_data [COLS];
  logic [COLS-1:0]        buf_mask;
  logic [COLS-1:0]        merged_mask;
  logic [DATA_W*COLS-1:0] merged_flat;

  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;

  // named internal events
  logic store_evt;
  logic line_end;
  logic flush_evt;
  logic commit_evt;

  function automatic logic [COL_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return a[COL_W-1:0];
  endfunction

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:COL_W];
  endfunction

  assign col        = col_of(wr_ptr);
  assign row        = row_of(wr_ptr);
  assign store_evt  = (kind == CYC_WRITE) && ie;
  assign line_end   = (kind == CYC_WRITE) && (col == COL_W'(COLS - 1));
  assign flush_evt  = (kind == CYC_RESET);
  assign commit_evt = line_end || flush_evt;
  assign merged_mask = buf_mask | (store_evt ? (COLS'(1) << col) : '0);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic hit;
    assign hit = store_evt && (col == COL_W'(c));
    assign merged_flat[c*DATA_W +: DATA_W] = hit ? din : buf_data[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) buf_data[c] <= '0;
      else if (hit) buf_data[c] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_mask <= '0;
      arr_we   <= 1'b0;
      arr_row  <= '0;
      arr_data <= '0;
      arr_mask <= '0;
    end else if (commit_evt) begin
      buf_mask <= '0;
      arr_we   <= |merged_mask;
      arr_row  <= row;
      arr_data <= merged_flat;
      arr_mask <= merged_mask;
    end else begin
      buf_mask <= merged_mask;
      arr_we   <= 1'b0;
    end
  end

  // R7
  commit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> $past(commit_evt));

  // R6
  commit_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_mask != '0));

  // R8
  no_early_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> !arr_we);
endmodule

// File: rtl/field_wr_port.sv
module field_wr_port
  import fwp_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned COL_W      = 9,
  parameter int unsigned ROW_W      = 9,
  parameter int unsigned MIN_ACTIVE = 80
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rst_req,
  input  logic                          we,
  input  logic                          ie,
  input  logic [DATA_W-1:0]             din,
  output logic [ROW_W+COL_W-1:0]        wr_ptr,
  output logic                          arr_we,
  output logic [ROW_W-1:0]              arr_row,
  output logic [DATA_W*(1<<COL_W)-1:0]  arr_data,
  output logic [(1<<COL_W)-1:0]         arr_mask,
  output logic                          rst_err,
  output logic                          short_pass
);
  localparam int unsigned ADDR_W = ROW_W + COL_W;

  cyc_kind_t kind;

  fwp_ptr_ctl #(
    .ADDR_W     (ADDR_W),
    .MIN_ACTIVE (MIN_ACTIVE)
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_req    (rst_req),
    .we         (we),
    .kind       (kind),
    .wr_ptr     (wr_ptr),
    .rst_err    (rst_err),
    .short_pass (short_pass)
  );

  fwp_line_stage #(
    .DATA_W (DATA_W),
    .COL_W  (COL_W),
    .ROW_W  (ROW_W)
  ) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (kind),
    .ie       (ie),
    .din      (din),
    .wr_ptr   (wr_ptr),
    .arr_we   (arr_we),
    .arr_row  (arr_row),
    .arr_data (arr_data),
    .arr_mask (arr_mask)
  );

  // R2
  reset_ignores_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_RESET) |=> (wr_ptr == '0));
endmodule

// File: tb/sim_field_wr_port.sv
module sim_field_wr_port;
  localparam int PERIOD = 10;
  localparam int DW = 8;
  localparam int CW = 3;
  localparam int RW = 2;
  localparam int COLS = 1 << CW;
  localparam int WORDS = COLS << RW;
  localparam int MINA = 80;

  // {rst_req, we, ie, din, expected wr_ptr}
  localparam logic [15:0] VEC [24] = '{
    {3'b100, 8'h00, 5'd0},  {3'b011, 8'hA1, 5'd1},  {3'b011, 8'hA2, 5'd2},
    {3'b001, 8'hFF, 5'd2},  {3'b000, 8'hFF, 5'd2},  {3'b010, 8'hA3, 5'd3},
    {3'b011, 8'hA4, 5'd4},  {3'b111, 8'hEE, 5'd0},  {3'b111, 8'hDD, 5'd1},
    {3'b011, 8'hB1, 5'd2},  {3'b101, 8'h00, 5'd2},  {3'b011, 8'hB2, 5'd3},
    {3'b011, 8'hB3, 5'd4},  {3'b110, 8'h00, 5'd0},  {3'b011, 8'hC0, 5'd1},
    {3'b011, 8'hC1, 5'd2},  {3'b011, 8'hC2, 5'd3},  {3'b011, 8'hC3, 5'd4},
    {3'b011, 8'hC4, 5'd5},  {3'b011, 8'hC5, 5'd6},  {3'b011, 8'hC6, 5'd7},
    {3'b011, 8'hC7, 5'd8},  {3'b011, 8'hC8, 5'd9},  {3'b011, 8'hC9, 5'd10}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_req = 1'b0, we = 1'b0, ie = 1'b0;
  logic [DW-1:0] din = '0;
  logic [RW+CW-1:0] wr_ptr;
  logic arr_we, rst_err, short_pass;
  logic [RW-1:0] arr_row;
  logic [DW*COLS-1:0] arr_data;
  logic [COLS-1:0] arr_mask;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench-side model state
  int m_ptr = 0, m_low = 2, m_cnt = 0;
  bit m_open = 0, m_short = 0, m_pend = 0, e_commit = 0, e_err = 0;
  logic [DW-1:0] ref_mem [WORDS];
  logic [DW-1:0] arr_mem [WORDS];

  always #(PERIOD/2) clk = ~clk;

  field_wr_port #(.DATA_W(DW), .COL_W(CW), .ROW_W(RW), .MIN_ACTIVE(MINA)) u0 (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .we(we), .ie(ie), .din(din),
    .wr_ptr(wr_ptr), .arr_we(arr_we), .arr_row(arr_row), .arr_data(arr_data),
    .arr_mask(arr_mask), .rst_err(rst_err), .short_pass(short_pass)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at a falling edge, update the model, check at the next falling edge
  task automatic step(input bit r, input bit w, input bit i, input logic [DW-1:0] d);
    bit acc;
    rst_req = r; we = w; ie = i; din = d;
    acc = r && (m_low >= 2);
    e_err = r && !acc;
    e_commit = 0;
    m_low = r ? 0 : ((m_low >= 2) ? 2 : m_low + 1);
    if (acc) begin
      e_commit = m_pend;
      m_pend = 0;
      m_short = m_open && (m_cnt < MINA);
      m_open = 1;
      m_cnt = 0;
      m_ptr = 0;
    end else if (w) begin
      if (i) begin
        ref_mem[m_ptr] = d;
        m_pend = 1;
      end
      if ((m_ptr % COLS) == COLS - 1) begin
        e_commit = m_pend;
        m_pend = 0;
      end
      m_ptr = (m_ptr + 1) % WORDS;
      if (m_cnt < MINA) m_cnt++;
    end
    @(negedge clk);
    chk(wr_ptr == (RW+CW)'(m_ptr), "R1/R4/R5 wr_ptr", int'(wr_ptr), m_ptr);
    chk(rst_err == e_err, "R3 rst_err", int'(rst_err), int'(e_err));
    chk(arr_we == e_commit, "R7/R8 arr_we", int'(arr_we), int'(e_commit));
    chk(short_pass == m_short, "R9 short_pass", int'(short_pass), int'(m_short));
    if (arr_we) begin
      for (int c = 0; c < COLS; c++)
        if (arr_mask[c]) arr_mem[int'(arr_row) * COLS + c] = arr_data[c*DW +: DW];
    end
  endtask

  task automatic compare_mem(input string tag);
    for (int a = 0; a < WORDS; a++)
      chk(arr_mem[a] == ref_mem[a], tag, int'(arr_mem[a]), int'(ref_mem[a]));
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < WORDS; a++) begin
      ref_mem[a] = '0;
      arr_mem[a] = '0;
    end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(wr_ptr == '0, "R1 reset wr_ptr", int'(wr_ptr), 0);
    chk(!arr_we && !rst_err && !short_pass, "R9 reset flags",
        int'({arr_we, rst_err, short_pass}), 0);

    // table walk: accepted and rejected resets, WE hold, IE mask, partial flush
    for (int k = 0; k < 24; k++) begin
      step(VEC[k][15], VEC[k][14], VEC[k][13], VEC[k][12:5]);
      chk(wr_ptr == VEC[k][4:0], "R1/R3/R5 table wr_ptr", int'(wr_ptr), int'(VEC[k][4:0]));
    end

    // R4: long hold with WE low, data toggling
    for (int k = 0; k < 10; k++) step(0, 0, 1, 8'(k * 17));

    // close the pass, then a long pass of 80 writes that wraps the pointer (R5)
    step(1, 1, 1, 8'h5A);
    step(0, 0, 0, 8'h00);
    step(0, 0, 0, 8'h00);
    for (int k = 0; k < MINA; k++) step(0, 1, 1, 8'(8'h40 + k));
    step(1, 0, 0, 8'h00);
    chk(short_pass == 1'b0, "R9 full pass not short", int'(short_pass), 0);
    compare_mem("R8 flush after long pass");

    // R6: masked pass over the whole array, keeps the old words where ie is low
    step(0, 0, 0, 8'h00);
    step(0, 0, 0, 8'h00);
    for (int k = 0; k < WORDS; k++) step(0, 1, (k % 3) != 0, 8'(8'h90 + k));
    step(1, 1, 1, 8'h77); // R2: WE/IE/din ignored on the reset edge
    chk(short_pass == 1'b1, "R9 short pass", int'(short_pass), 1);
    compare_mem("R6 masked locations keep old data");

    // R8: partial row left pending, then flushed by the next reset
    step(0, 0, 0, 8'h00);
    step(0, 0, 0, 8'h00);
    step(0, 1, 1, 8'h11);
    step(0, 1, 0, 8'h22);
    step(0, 1, 1, 8'h33);
    chk(arr_mem[0] != 8'h11, "R8 no commit before reset", int'(arr_mem[0]), 8'h11);
    step(1, 0, 0, 8'h00);
    compare_mem("R8 partial flush");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule